// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block caches recent page-to-frame translations in a small, fully associative store. Each entry holds a key and a value. The key is a virtual page number plus an address-space identifier (ASID). The value is a frame number plus protection bits. A requester presents a page number together with the ASID of the running process. The block compares that key against every entry at once and answers one cycle later with hit or miss, the frame and the protection bits.

A miss moves the controller from `S_READY` to `S_WALK`. In that state the block raises a walk request carrying the missed key and stops accepting lookups. The external table walker answers with a refill. An accepted refill moves the controller back to `S_READY` (transition `WALK_DONE`). A hit, or a lookup while idle, keeps it in `S_READY` (transition `STAY_READY`); a miss takes transition `MISS_START`.

Entries from several processes can sit side by side, because a hit needs the ASID to agree. When ASID checking is switched off, only the page is compared. In that mode a context-switch pulse clears the whole store. Software may also clear everything with a flush, or clear only the entries of one ASID.

Top module: `asid_tlb`

## Requirements
- R1: After reset, every entry is invalid, `rsp_valid` and `walk_req` are 0, and `lkp_ready` is 1.
- R2: A lookup accepted in a cycle (`lkp_valid` with `lkp_ready`) produces `rsp_valid`=1 on the next cycle. `rsp_hit` is 1 only when a valid entry holds the same page and, with `asid_en`=1, the same ASID; a hit returns that entry's frame and protection bits. On a miss, `rsp_frame` and `rsp_perm` are 0.
- R3: With `asid_en`=1, an entry whose page matches but whose ASID differs gives a miss. Entries with the same page but different ASIDs coexist, and each returns its own frame.
- R4: With `asid_en`=0, the ASID is ignored in the comparison and a `ctx_switch` pulse invalidates every entry. With `asid_en`=1, `ctx_switch` has no effect.
- R5: A miss takes the controller to `S_WALK` in the same cycle that the miss response appears. In `S_WALK`, `walk_req`=1, `walk_vpn` and `walk_asid` hold the missed key, `lkp_ready`=0, and lookups produce no response.
- R6: An accepted refill (`fill_valid`) writes its page, ASID, frame and protection bits into the store, in either state. In `S_WALK` it returns the controller to `S_READY` on the next cycle. A later lookup of that key hits.
- R7: A refill whose key already matches a valid entry overwrites that entry, so no key is ever stored twice.
- R8: A refill with no matching entry takes the lowest-numbered invalid entry. If every entry is valid, it replaces the entry under a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, after each such replacement.
- R9: `flush_all` invalidates every entry in one cycle. `inv_asid_valid` invalidates, in one cycle, exactly the entries whose stored ASID equals `inv_asid` and leaves the others valid.
- R10: A refill presented in the same cycle as a flush, an ASID invalidate or any other clearing event is dropped. The controller stays in its state.
- R11: Any change of `asid_en` invalidates every entry on the next clock edge.
- R12: At most one entry matches a lookup key in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| asid_en | input | 1 | 1: ASID takes part in the match; 0: page only |
| ctx_switch | input | 1 | Context switch; clears all entries when `asid_en`=0 |
| flush_all | input | 1 | Invalidate every entry |
| inv_asid_valid | input | 1 | Invalidate entries of one ASID |
| inv_asid | input | ASID_W | ASID to invalidate |
| lkp_valid | input | 1 | Lookup request |
| lkp_vpn | input | VPN_W | Lookup page number |
| lkp_asid | input | ASID_W | ASID of the running process |
| lkp_ready | output | 1 | Controller in `S_READY`; lookups accepted |
| rsp_valid | output | 1 | Response present (one cycle after the lookup) |
| rsp_hit | output | 1 | Translation found |
| rsp_frame | output | FRAME_W | Frame number on hit, 0 on miss |
| rsp_perm | output | PERM_W | Protection bits on hit, 0 on miss |
| walk_req | output | 1 | Table walk needed (controller in `S_WALK`) |
| walk_vpn | output | VPN_W | Page number that missed |
| walk_asid | output | ASID_W | ASID of the lookup that missed |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | VPN_W | Refill page number |
| fill_asid | input | ASID_W | Refill ASID |
| fill_frame | input | FRAME_W | Refill frame number |
| fill_perm | input | PERM_W | Refill protection bits |

## Verification
Several properties are checked on every cycle:

- No more than one entry matches a key.
- A clearing event leaves no valid entry behind, and an ASID invalidate leaves no valid entry carrying that ASID.
- A refill never lands on a valid entry while an invalid one is free.
- A walk starts only alongside a miss response and holds its key until a refill is accepted.
- A miss response always carries zero frame and protection bits.

Other behaviour shows only in the directed scenarios:

- The frame returned for a given key, and whether entries of different ASIDs coexist.
- The round-robin victim order once the store is full.
- That an overwrite keeps a single copy.
- That clearing by mode change or context switch depends on `asid_en`.
- That a refill coinciding with a clear is dropped.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    // Controller states: idle and accepting lookups, or waiting for a walk result
    typedef enum logic [0:0] {
        S_READY = 1'b0,
        S_WALK  = 1'b1
    } tlb_state_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int FRAME_W = 20,
    parameter int PERM_W  = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               asid_en_i,
    input  logic [VPN_W-1:0]   lkp_vpn_i,
    input  logic [ASID_W-1:0]  lkp_asid_i,
    input  logic [VPN_W-1:0]   wr_vpn_i,
    input  logic [ASID_W-1:0]  wr_asid_i,
    input  logic [FRAME_W-1:0] wr_frame_i,
    input  logic [PERM_W-1:0]  wr_perm_i,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic               clr_all_i,
    input  logic               inv_en_i,
    input  logic [ASID_W-1:0]  inv_asid_i,
    output logic [ENTRIES-1:0] lkp_match_o,
    output logic [ENTRIES-1:0] wr_match_o,
    output logic [ENTRIES-1:0] valid_o,
    output logic [FRAME_W-1:0] lkp_frame_o,
    output logic [PERM_W-1:0]  lkp_perm_o
);

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q   [ENTRIES];
    logic [ASID_W-1:0]  asid_q  [ENTRIES];
    logic [FRAME_W-1:0] frame_q [ENTRIES];
    logic [PERM_W-1:0]  perm_q  [ENTRIES];
    logic               wr_ok;

    // Clearing events win over a write in the same cycle
    assign wr_ok   = wr_en_i && !clr_all_i && !inv_en_i;
    assign valid_o = valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (clr_all_i)
                    valid_q[i] <= 1'b0;
                else if (inv_en_i && asid_q[i] == inv_asid_i)
                    valid_q[i] <= 1'b0;
                else if (wr_ok && wr_idx_i == IDX_W'(i))
                    valid_q[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            vpn_q[wr_idx_i]   <= wr_vpn_i;
            asid_q[wr_idx_i]  <= wr_asid_i;
            frame_q[wr_idx_i] <= wr_frame_i;
            perm_q[wr_idx_i]  <= wr_perm_i;
        end
    end

    // One comparator pair per entry: lookup key and refill key
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign lkp_match_o[g] = valid_q[g] && vpn_q[g] == lkp_vpn_i &&
                                (!asid_en_i || asid_q[g] == lkp_asid_i);
        assign wr_match_o[g]  = valid_q[g] && vpn_q[g] == wr_vpn_i &&
                                (!asid_en_i || asid_q[g] == wr_asid_i);

        AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (inv_en_i && asid_q[g] == inv_asid_i) |=> !valid_q[g]); // R9
    end

    always_comb begin
        lkp_frame_o = '0;
        lkp_perm_o  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lkp_frame_o = lkp_frame_o | ({FRAME_W{lkp_match_o[i]}} & frame_q[i]);
            lkp_perm_o  = lkp_perm_o  | ({PERM_W{lkp_match_o[i]}} & perm_q[i]);
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lkp_match_o)); // R12

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (valid_q == '0)); // R9

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] hit_i,
    input  logic               commit_i,
    output logic [IDX_W-1:0]   idx_o
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_hit;
    logic             full;

    assign any_hit = |hit_i;
    assign full    = &valid_i;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_i[i])   hit_idx  = IDX_W'(i);
            if (!valid_i[i]) free_idx = IDX_W'(i);
        end
    end

    // Priority: existing match, then lowest free slot, then round-robin
    assign idx_o = any_hit ? hit_idx : (full ? ptr_q : free_idx);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (commit_i && !any_hit && full)
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end

    AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !any_hit && !full) |-> !valid_i[idx_o]); // R8

    AST_OVERWRITE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && any_hit) |-> hit_i[idx_o]); // R7

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int FRAME_W = 20,
    parameter int PERM_W  = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               asid_en,
    input  logic               ctx_switch,
    input  logic               flush_all,
    input  logic               inv_asid_valid,
    input  logic [ASID_W-1:0]  inv_asid,
    input  logic               lkp_valid,
    input  logic [VPN_W-1:0]   lkp_vpn,
    input  logic [ASID_W-1:0]  lkp_asid,
    output logic               lkp_ready,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [FRAME_W-1:0] rsp_frame,
    output logic [PERM_W-1:0]  rsp_perm,
    output logic               walk_req,
    output logic [VPN_W-1:0]   walk_vpn,
    output logic [ASID_W-1:0]  walk_asid,
    input  logic               fill_valid,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic [PERM_W-1:0]  fill_perm
);

    tlb_state_e         state_q, state_d;
    logic               asid_en_q;
    logic               mode_chg;
    logic               clr_all;
    logic               fill_ok;
    logic               lkp_fire;
    logic               lkp_hit_now;
    logic               miss_now;
    logic [ENTRIES-1:0] lkp_match;
    logic [ENTRIES-1:0] wr_match;
    logic [ENTRIES-1:0] valid_vec;
    logic [FRAME_W-1:0] hit_frame;
    logic [PERM_W-1:0]  hit_perm;
    logic [IDX_W-1:0]   wr_idx;

    assign mode_chg    = asid_en != asid_en_q;
    assign clr_all     = flush_all || (ctx_switch && !asid_en) || mode_chg;
    assign fill_ok     = fill_valid && !clr_all && !inv_asid_valid;
    assign lkp_ready   = (state_q == S_READY);
    assign walk_req    = (state_q == S_WALK);
    assign lkp_fire    = lkp_valid && lkp_ready;
    assign lkp_hit_now = |lkp_match;
    assign miss_now    = lkp_fire && !lkp_hit_now;

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W),
        .FRAME_W (FRAME_W),
        .PERM_W  (PERM_W)
    ) u_cam (
        .clk         (clk),
        .rst_n       (rst_n),
        .asid_en_i   (asid_en),
        .lkp_vpn_i   (lkp_vpn),
        .lkp_asid_i  (lkp_asid),
        .wr_vpn_i    (fill_vpn),
        .wr_asid_i   (fill_asid),
        .wr_frame_i  (fill_frame),
        .wr_perm_i   (fill_perm),
        .wr_en_i     (fill_ok),
        .wr_idx_i    (wr_idx),
        .clr_all_i   (clr_all),
        .inv_en_i    (inv_asid_valid),
        .inv_asid_i  (inv_asid),
        .lkp_match_o (lkp_match),
        .wr_match_o  (wr_match),
        .valid_o     (valid_vec),
        .lkp_frame_o (hit_frame),
        .lkp_perm_o  (hit_perm)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_vec),
        .hit_i    (wr_match),
        .commit_i (fill_ok),
        .idx_o    (wr_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_READY;
            asid_en_q <= 1'b1;
        end else begin
            state_q   <= state_d;
            asid_en_q <= asid_en;
        end
    end

    // Transitions: STAY_READY, MISS_START, WALK_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_READY: if (miss_now) state_d = S_WALK;
            S_WALK:  if (fill_ok)  state_d = S_READY;
            default: state_d = S_READY;
        endcase
    end

    // Registered response and walk key
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_frame <= '0;
            rsp_perm  <= '0;
            walk_vpn  <= '0;
            walk_asid <= '0;
        end else begin
            rsp_valid <= lkp_fire;
            rsp_hit   <= lkp_fire && lkp_hit_now;
            rsp_frame <= (lkp_fire && lkp_hit_now) ? hit_frame : '0;
            rsp_perm  <= (lkp_fire && lkp_hit_now) ? hit_perm  : '0;
            if (miss_now) begin
                walk_vpn  <= lkp_vpn;
                walk_asid <= lkp_asid;
            end
        end
    end

    AST_WALK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_req) |-> (rsp_valid && !rsp_hit)); // R5

    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_ok) |=> (walk_req && $stable(walk_vpn) && $stable(walk_asid))); // R5

    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lkp_valid && lkp_ready)); // R2

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_frame == '0 && rsp_perm == '0)); // R2

    AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |=> !rsp_valid); // R5

endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;

    localparam int ENTRIES = 16;
    localparam int VPN_W   = 20;
    localparam int ASID_W  = 8;
    localparam int FRAME_W = 20;
    localparam int PERM_W  = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               asid_en = 1'b1;
    logic               ctx_switch = 1'b0;
    logic               flush_all = 1'b0;
    logic               inv_asid_valid = 1'b0;
    logic [ASID_W-1:0]  inv_asid = '0;
    logic               lkp_valid = 1'b0;
    logic [VPN_W-1:0]   lkp_vpn = '0;
    logic [ASID_W-1:0]  lkp_asid = '0;
    logic               lkp_ready;
    logic               rsp_valid;
    logic               rsp_hit;
    logic [FRAME_W-1:0] rsp_frame;
    logic [PERM_W-1:0]  rsp_perm;
    logic               walk_req;
    logic [VPN_W-1:0]   walk_vpn;
    logic [ASID_W-1:0]  walk_asid;
    logic               fill_valid = 1'b0;
    logic [VPN_W-1:0]   fill_vpn = '0;
    logic [ASID_W-1:0]  fill_asid = '0;
    logic [FRAME_W-1:0] fill_frame = '0;
    logic [PERM_W-1:0]  fill_perm = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    asid_tlb #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .FRAME_W(FRAME_W), .PERM_W(PERM_W)
    ) u_asid_tlb (
        .clk(clk), .rst_n(rst_n), .asid_en(asid_en), .ctx_switch(ctx_switch),
        .flush_all(flush_all), .inv_asid_valid(inv_asid_valid), .inv_asid(inv_asid),
        .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn), .lkp_asid(lkp_asid),
        .lkp_ready(lkp_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_frame(rsp_frame), .rsp_perm(rsp_perm), .walk_req(walk_req),
        .walk_vpn(walk_vpn), .walk_asid(walk_asid), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_frame(fill_frame),
        .fill_perm(fill_perm)
    );

    function automatic logic [FRAME_W-1:0] walk_frame(input logic [VPN_W-1:0] v);
        return v + 20'h5000;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge
    task automatic do_fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                           input logic [FRAME_W-1:0] f, input logic [PERM_W-1:0] p);
        fill_valid = 1'b1; fill_vpn = v; fill_asid = a; fill_frame = f; fill_perm = p;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    task automatic do_inv(input logic [ASID_W-1:0] a);
        inv_asid_valid = 1'b1; inv_asid = a;
        @(negedge clk);
        inv_asid_valid = 1'b0;
    endtask

    task automatic do_ctx();
        ctx_switch = 1'b1;
        @(negedge clk);
        ctx_switch = 1'b0;
    endtask

    // Lookup, check response; on a miss check the walk key and optionally refill
    task automatic probe(input string req, input logic [VPN_W-1:0] v,
                         input logic [ASID_W-1:0] a, input bit exp_hit,
                         input logic [FRAME_W-1:0] exp_f, input logic [PERM_W-1:0] exp_p,
                         input bit refill);
        lkp_valid = 1'b1; lkp_vpn = v; lkp_asid = a;
        @(negedge clk);
        lkp_valid = 1'b0;
        chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(req, "rsp_hit", 32'(rsp_hit), 32'(exp_hit));
        chk(req, "rsp_frame", 32'(rsp_frame), exp_hit ? 32'(exp_f) : 32'd0);
        chk(req, "rsp_perm", 32'(rsp_perm), exp_hit ? 32'(exp_p) : 32'd0);
        if (!exp_hit && !rsp_hit) begin
            chk("R5", "walk_req", 32'(walk_req), 32'd1);
            chk("R5", "walk_vpn", 32'(walk_vpn), 32'(v));
            chk("R5", "walk_asid", 32'(walk_asid), 32'(a));
            chk("R5", "lkp_ready", 32'(lkp_ready), 32'd0);
            if (refill) begin
                do_fill(v, a, walk_frame(v), 3'b101);
                chk("R6", "ready after refill", 32'(lkp_ready), 32'd1);
            end
        end
    endtask

    task automatic t_reset();
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "walk_req", 32'(walk_req), 32'd0);
        chk("R1", "lkp_ready", 32'(lkp_ready), 32'd1);
        probe("R1", 20'h00000, 8'd0, 1'b0, '0, '0, 1'b1);
    endtask

    task automatic t_basic();
        do_flush();
        do_fill(20'h12345, 8'd3, 20'hABCDE, 3'b011);
        probe("R2", 20'h12345, 8'd3, 1'b1, 20'hABCDE, 3'b011, 1'b0);
        probe("R2", 20'h12346, 8'd3, 1'b0, '0, '0, 1'b1);
        probe("R6", 20'h12346, 8'd3, 1'b1, walk_frame(20'h12346), 3'b101, 1'b0);
    endtask

    task automatic t_walk_blocks();
        probe("R5", 20'h22222, 8'd3, 1'b0, '0, '0, 1'b0);
        lkp_valid = 1'b1; lkp_vpn = 20'h12345; lkp_asid = 8'd3;
        @(negedge clk);
        lkp_valid = 1'b0;
        chk("R5", "lookup ignored in walk", 32'(rsp_valid), 32'd0);
        chk("R5", "walk_req held", 32'(walk_req), 32'd1);
        do_fill(20'h22222, 8'd3, 20'h0C0DE, 3'b001);
        chk("R6", "back to ready", 32'(lkp_ready), 32'd1);
        probe("R6", 20'h22222, 8'd3, 1'b1, 20'h0C0DE, 3'b001, 1'b0);
    endtask

    task automatic t_asid_coexist();
        do_flush();
        do_fill(20'h00777, 8'd1, 20'h11111, 3'b100);
        do_fill(20'h00777, 8'd2, 20'h22222, 3'b010);
        probe("R3", 20'h00777, 8'd1, 1'b1, 20'h11111, 3'b100, 1'b0);
        probe("R3", 20'h00777, 8'd2, 1'b1, 20'h22222, 3'b010, 1'b0);
        probe("R3", 20'h00777, 8'd3, 1'b0, '0, '0, 1'b1);
    endtask

    task automatic t_flush_inv();
        do_flush();
        do_fill(20'h00300, 8'd1, 20'h03000, 3'b111);
        do_fill(20'h00301, 8'd2, 20'h03010, 3'b110);
        do_fill(20'h00302, 8'd1, 20'h03020, 3'b111);
        do_inv(8'd1);
        probe("R9", 20'h00301, 8'd2, 1'b1, 20'h03010, 3'b110, 1'b0);
        probe("R9", 20'h00300, 8'd1, 1'b0, '0, '0, 1'b1);
        probe("R9", 20'h00302, 8'd1, 1'b0, '0, '0, 1'b1);
        do_flush();
        probe("R9", 20'h00301, 8'd2, 1'b0, '0, '0, 1'b1);
    endtask

    task automatic t_replace();
        do_flush();
        for (int i = 0; i < ENTRIES; i++)
            do_fill(VPN_W'(32'h100 + i), 8'd1, FRAME_W'(32'h200 + i), 3'b001);
        probe("R8", 20'h0010F, 8'd1, 1'b1, 20'h0020F, 3'b001, 1'b0);
        probe("R8", 20'h00100, 8'd1, 1'b1, 20'h00200, 3'b001, 1'b0);
        do_fill(20'h00110, 8'd1, 20'h00210, 3'b001);
        probe("R8", 20'h00100, 8'd1, 1'b0, '0, '0, 1'b1);
        probe("R8", 20'h00101, 8'd1, 1'b0, '0, '0, 1'b1);
        probe("R8", 20'h00103, 8'd1, 1'b1, 20'h00203, 3'b001, 1'b0);
        probe("R8", 20'h00110, 8'd1, 1'b1, 20'h00210, 3'b001, 1'b0);
        probe("R8", 20'h00100, 8'd1, 1'b1, walk_frame(20'h00100), 3'b101, 1'b0);
    endtask

    task automatic t_overwrite();
        do_flush();
        do_fill(20'h00444, 8'd4, 20'h0F0F0, 3'b010);
        do_fill(20'h00444, 8'd4, 20'h00F0F, 3'b100);
        probe("R7", 20'h00444, 8'd4, 1'b1, 20'h00F0F, 3'b100, 1'b0);
    endtask

    task automatic t_priority();
        do_flush();
        probe("R10", 20'h00400, 8'd4, 1'b0, '0, '0, 1'b0);
        flush_all = 1'b1;
        do_fill(20'h00400, 8'd4, 20'h04000, 3'b011);
        flush_all = 1'b0;
        chk("R10", "walk_req after dropped fill", 32'(walk_req), 32'd1);
        chk("R10", "lkp_ready after dropped fill", 32'(lkp_ready), 32'd0);
        do_fill(20'h00400, 8'd4, 20'h04000, 3'b011);
        chk("R10", "ready after real fill", 32'(lkp_ready), 32'd1);
        probe("R10", 20'h00400, 8'd4, 1'b1, 20'h04000, 3'b011, 1'b0);
        inv_asid_valid = 1'b1; inv_asid = 8'd9;
        do_fill(20'h00401, 8'd5, 20'h04010, 3'b011);
        inv_asid_valid = 1'b0;
        probe("R10", 20'h00401, 8'd5, 1'b0, '0, '0, 1'b1);
    endtask

    task automatic t_no_asid();
        do_flush();
        do_fill(20'h00500, 8'd1, 20'h05000, 3'b001);
        probe("R11", 20'h00500, 8'd1, 1'b1, 20'h05000, 3'b001, 1'b0);
        asid_en = 1'b0;
        @(negedge clk);
        probe("R11", 20'h00500, 8'd1, 1'b0, '0, '0, 1'b1);
        probe("R4", 20'h00500, 8'd7, 1'b1, walk_frame(20'h00500), 3'b101, 1'b0);
        do_ctx();
        probe("R4", 20'h00500, 8'd1, 1'b0, '0, '0, 1'b1);
        asid_en = 1'b1;
        @(negedge clk);
        probe("R11", 20'h00500, 8'd1, 1'b0, '0, '0, 1'b1);
        do_fill(20'h00600, 8'd2, 20'h06000, 3'b010);
        do_ctx();
        probe("R4", 20'h00600, 8'd2, 1'b1, 20'h06000, 3'b010, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_walk_blocks();
        t_asid_coexist();
        t_flush_inv();
        t_replace();
        t_overwrite();
        t_priority();
        t_no_asid();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=not finished expected=finished within 20000 cycles");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule